// File: doc/BRIEF.md
# Programmable Video Sync Timing Generator

This block sets the raster timing for a pixel port whose clock runs at twice the pixel rate. Every pixel therefore spans two clocks: a read slot and a write slot. It keeps a pixel counter within the line and a line counter within the frame. From these counters it derives active-low horizontal and vertical sync and the active-low strobes that frame the active image. The counters are also brought out so that downstream logic can form buffer addresses.

In master mode the block drives both syncs from its own counters, using programmed period and sync-width values. In slave mode it releases the sync lines and follows external syncs instead. A falling horizontal sync restarts the pixel count and advances the line count. A falling vertical sync restarts the line count.

The horizontal period and sync-width registers are stored as the count minus one, and they count pixel pairs in grayscale. The active width is given in blocks: 8 pixels per unit in color, 16 in grayscale. A stall input freezes all timing.

Top module: `vid_sync_gen`

## Requirements
- R1: With `master`=1 the block drives both syncs (`hsync_oe`=`vsync_oe`=1). With `master`=0 both enables are 0 and the block only samples `hsync_in`/`vsync_in`.
- R2: In color mode (`gray`=0) and master mode, the HSync falls every `hperiod`+1 pixels (2·(`hperiod`+1) clocks) and stays low for `hsync_w`+1 pixels.
- R3: In grayscale mode (`gray`=1) the horizontal period is 2·(`hperiod`+1) pixels and the HSync low time is 2·(`hsync_w`+1) pixels.
- R4: In master mode the VSync falls every `vperiod` lines and stays low for `vsync_w`+1 lines. A line lasts one horizontal period.
- R5: The horizontal window opens `hdelay` pixels after the HSync fall, with `pix_cnt` = `hdelay` at the first active pixel. It is `hactive`·8 pixels wide in color and `hactive`·16 in grayscale.
- R6: `line_cnt` is 0 on the line that starts at the VSync fall and advances at each HSync fall. The vertical window covers lines `vdelay` to `vdelay`+`vactive`−1.
- R7: Inside both windows, `px_in_n` is low when `decode`=0 and `px_out_n` is low when `decode`=1. The other strobe stays high, and both strobes are high outside the windows.
- R8: `slot` alternates 0 (read) and 1 (write) every clock. `pix_cnt` advances only at the end of a write slot.
- R9: While `stall`=1, the counters, slot and syncs hold their values and both strobes are high.
- R10: In slave mode, a falling `hsync_in` sets `pix_cnt` to 0 and increments `line_cnt` one clock later. A falling `vsync_in` sets `line_cnt` to 0 one clock later.
- R11: During reset `pix_cnt`=0, `line_cnt`=0 and `slot`=0. In master mode both syncs are then low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock, twice the pixel rate |
| rst | input | 1 | Synchronous reset, active high |
| master | input | 1 | 1: drive syncs, 0: follow external syncs |
| gray | input | 1 | 1: grayscale, 0: color |
| decode | input | 1 | 0: pixels enter (px_in_n), 1: pixels leave (px_out_n) |
| hperiod | input | HW | Line period minus one (pixel pairs in grayscale) |
| hsync_w | input | HW | HSync low time minus one (pixel pairs in grayscale) |
| hdelay | input | HW+1 | Pixels from HSync fall to first active pixel |
| hactive | input | HW | Active width in 8- or 16-pixel blocks |
| vperiod | input | VW | Lines per frame |
| vsync_w | input | VW | VSync low lines minus one |
| vdelay | input | VW | Lines from VSync fall to first active line |
| vactive | input | VW | Active lines |
| stall | input | 1 | Freeze all timing |
| hsync_in | input | 1 | External HSync, active low |
| vsync_in | input | 1 | External VSync, active low |
| hsync_out | output | 1 | Driven HSync, active low |
| hsync_oe | output | 1 | HSync driver enable |
| vsync_out | output | 1 | Driven VSync, active low |
| vsync_oe | output | 1 | VSync driver enable |
| px_in_n | output | 1 | Active-low pixel-in window strobe |
| px_out_n | output | 1 | Active-low pixel-out window strobe |
| slot | output | 1 | 0 read slot, 1 write slot |
| pix_cnt | output | HW+1 | Pixel index since HSync fall |
| line_cnt | output | VW | Line index since VSync fall |

## Verification
The case that is hardest to reach from the ports is a stall that lands inside the active window. The strobe must be forced high there, while the counters and syncs freeze at the position they held. The stimulus waits at the falling clock edge until the pixel-in strobe is seen low, raises the stall there, and holds it for ten clocks. It checks that the pixel count and sync level are unchanged and the strobe is high throughout, then releases the stall. Slave alignment is reached in a similar way. The counters first run free from reset, then an external falling sync edge is injected away from any natural wrap, so that the restart of the count can only come from the edge.

// File: rtl/vsg_pkg.sv
package vsg_pkg;
    localparam int H_BITS = 10;
    localparam int V_BITS = 11;

    typedef enum logic {SLOT_RD = 1'b0, SLOT_WR = 1'b1} slot_e;

    typedef struct packed {
        logic master;
        logic gray;
        logic decode;
    } vsg_mode_t;

    // minus-one horizontal register to pixels, doubled in grayscale
    function automatic int unsigned units_to_px(input int unsigned v, input logic g);
        return g ? 2 * (v + 1) : v + 1;
    endfunction

    // active width in blocks to pixels
    function automatic int unsigned blocks_to_px(input int unsigned v, input logic g);
        return g ? v * 16 : v * 8;
    endfunction
endpackage

// File: rtl/vsg_haxis.sv
module vsg_haxis
    import vsg_pkg::*;
#(
    parameter int HW = H_BITS,
    localparam int PW = HW + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  vsg_mode_t     mode,
    input  logic          stall,
    input  logic [HW-1:0] hperiod,
    input  logic [HW-1:0] hsync_w,
    input  logic          hsync_in,
    output logic [PW-1:0] pix,
    output slot_e         slot,
    output logic          line_step,
    output logic          hs_low
);
    logic        hs_q;
    logic        hfall;
    logic        at_end;
    int unsigned per_px;
    int unsigned low_px;

    always_comb begin
        per_px = units_to_px(32'(hperiod), mode.gray);
        low_px = units_to_px(32'(hsync_w), mode.gray);
        at_end = (32'(pix) + 1) >= per_px;
        hfall  = hs_q & ~hsync_in;
        hs_low = 32'(pix) < low_px;
        if (mode.master)
            line_step = !stall && (slot == SLOT_WR) && at_end;
        else
            line_step = !stall && hfall;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pix  <= '0;
            slot <= SLOT_RD;
            hs_q <= 1'b1;
        end else if (!stall) begin
            hs_q <= hsync_in;
            if (!mode.master && hfall) begin
                pix  <= '0;
                slot <= SLOT_RD;
            end else begin
                slot <= (slot == SLOT_RD) ? SLOT_WR : SLOT_RD;
                if (slot == SLOT_WR)
                    pix <= (mode.master && at_end) ? '0 : pix + 1'b1;
            end
        end
    end
endmodule

// File: rtl/vsg_vaxis.sv
module vsg_vaxis
    import vsg_pkg::*;
#(
    parameter int VW = V_BITS
) (
    input  logic          clk,
    input  logic          rst,
    input  vsg_mode_t     mode,
    input  logic          stall,
    input  logic          line_step,
    input  logic [VW-1:0] vperiod,
    input  logic [VW-1:0] vsync_w,
    input  logic          vsync_in,
    output logic [VW-1:0] line,
    output logic          vs_low
);
    logic vs_q;
    logic vfall;
    logic last_line;

    always_comb begin
        vfall     = vs_q & ~vsync_in;
        last_line = (32'(line) + 1) >= 32'(vperiod);
        vs_low    = line <= vsync_w;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            line <= '0;
            vs_q <= 1'b1;
        end else if (!stall) begin
            vs_q <= vsync_in;
            if (!mode.master && vfall)
                line <= '0;
            else if (line_step)
                line <= (mode.master && last_line) ? '0 : line + 1'b1;
        end
    end
endmodule

// File: rtl/vsg_window.sv
module vsg_window
    import vsg_pkg::*;
#(
    parameter int HW = H_BITS,
    parameter int VW = V_BITS,
    localparam int PW = HW + 1
) (
    input  vsg_mode_t     mode,
    input  logic          stall,
    input  logic [PW-1:0] pix,
    input  logic [VW-1:0] line,
    input  logic [PW-1:0] hdelay,
    input  logic [HW-1:0] hactive,
    input  logic [VW-1:0] vdelay,
    input  logic [VW-1:0] vactive,
    output logic          px_in_n,
    output logic          px_out_n
);
    logic        h_on;
    logic        v_on;
    logic        live;
    int unsigned width_px;

    always_comb begin
        width_px = blocks_to_px(32'(hactive), mode.gray);
        h_on     = (32'(pix) >= 32'(hdelay)) && (32'(pix) < 32'(hdelay) + width_px);
        v_on     = (32'(line) >= 32'(vdelay)) && (32'(line) < 32'(vdelay) + 32'(vactive));
        live     = h_on && v_on && !stall;
        px_in_n  = ~(live && !mode.decode);
        px_out_n = ~(live && mode.decode);
    end
endmodule

// File: rtl/vid_sync_gen.sv
module vid_sync_gen
    import vsg_pkg::*;
#(
    parameter int HW = H_BITS,
    parameter int VW = V_BITS,
    localparam int PW = HW + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          master,
    input  logic          gray,
    input  logic          decode,
    input  logic [HW-1:0] hperiod,
    input  logic [HW-1:0] hsync_w,
    input  logic [PW-1:0] hdelay,
    input  logic [HW-1:0] hactive,
    input  logic [VW-1:0] vperiod,
    input  logic [VW-1:0] vsync_w,
    input  logic [VW-1:0] vdelay,
    input  logic [VW-1:0] vactive,
    input  logic          stall,
    input  logic          hsync_in,
    input  logic          vsync_in,
    output logic          hsync_out,
    output logic          hsync_oe,
    output logic          vsync_out,
    output logic          vsync_oe,
    output logic          px_in_n,
    output logic          px_out_n,
    output logic          slot,
    output logic [PW-1:0] pix_cnt,
    output logic [VW-1:0] line_cnt
);
    vsg_mode_t mode;
    slot_e     slot_q;
    logic      line_step;
    logic      hs_low;
    logic      vs_low;

    assign mode = '{master: master, gray: gray, decode: decode};

    vsg_haxis #(.HW(HW)) u_h (
        .clk(clk), .rst(rst), .mode(mode), .stall(stall),
        .hperiod(hperiod), .hsync_w(hsync_w), .hsync_in(hsync_in),
        .pix(pix_cnt), .slot(slot_q), .line_step(line_step), .hs_low(hs_low)
    );

    vsg_vaxis #(.VW(VW)) u_v (
        .clk(clk), .rst(rst), .mode(mode), .stall(stall),
        .line_step(line_step), .vperiod(vperiod), .vsync_w(vsync_w),
        .vsync_in(vsync_in), .line(line_cnt), .vs_low(vs_low)
    );

    vsg_window #(.HW(HW), .VW(VW)) u_w (
        .mode(mode), .stall(stall), .pix(pix_cnt), .line(line_cnt),
        .hdelay(hdelay), .hactive(hactive), .vdelay(vdelay), .vactive(vactive),
        .px_in_n(px_in_n), .px_out_n(px_out_n)
    );

    assign slot      = slot_q;
    assign hsync_oe  = master;
    assign vsync_oe  = master;
    assign hsync_out = master ? ~hs_low : 1'b1;
    assign vsync_out = master ? ~vs_low : 1'b1;
endmodule

// File: rtl/vsg_checker.sv
module vsg_checker #(
    parameter int PW = 11,
    parameter int VW = 11
) (
    input logic          clk,
    input logic          rst,
    input logic          master,
    input logic          stall,
    input logic          hsync_in,
    input logic          hsync_oe,
    input logic          vsync_oe,
    input logic          px_in_n,
    input logic          px_out_n,
    input logic          slot,
    input logic [PW-1:0] pix_cnt,
    input logic [VW-1:0] line_cnt
);
    a_r1_slave_released: assert property (@(posedge clk) disable iff (rst)
        !master |-> (!hsync_oe && !vsync_oe));

    a_r7_one_strobe: assert property (@(posedge clk) disable iff (rst)
        !(!px_in_n && !px_out_n));

    a_r8_read_slot_hold: assert property (@(posedge clk) disable iff (rst)
        (master && !stall && !slot) |=> $stable(pix_cnt));

    a_r9_stall_freeze: assert property (@(posedge clk) disable iff (rst)
        stall |=> ($stable(pix_cnt) && $stable(line_cnt) && $stable(slot)));

    a_r9_stall_strobes: assert property (@(posedge clk) disable iff (rst)
        stall |-> (px_in_n && px_out_n));

    a_r10_slave_align: assert property (@(posedge clk) disable iff (rst)
        (!master && !stall && !$past(stall) && !$past(rst) && $fell(hsync_in)) |=> (pix_cnt == '0));
endmodule

bind vid_sync_gen vsg_checker #(.PW(PW), .VW(VW)) u_chk (
    .clk(clk), .rst(rst), .master(master), .stall(stall), .hsync_in(hsync_in),
    .hsync_oe(hsync_oe), .vsync_oe(vsync_oe), .px_in_n(px_in_n), .px_out_n(px_out_n),
    .slot(slot), .pix_cnt(pix_cnt), .line_cnt(line_cnt)
);

// File: tb/sim_vid_sync_gen.sv
module sim_vid_sync_gen;
    localparam int HW = 10;
    localparam int VW = 11;
    localparam int PW = HW + 1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic master = 1'b1, gray = 1'b0, decode = 1'b0, stall = 1'b0;
    logic hsync_in = 1'b1, vsync_in = 1'b1;
    logic [HW-1:0] hperiod = 10'd9, hsync_w = 10'd2, hactive = 10'd1;
    logic [PW-1:0] hdelay = 11'd3;
    logic [VW-1:0] vperiod = 11'd5, vsync_w = 11'd1, vdelay = 11'd1, vactive = 11'd2;
    logic hsync_out, hsync_oe, vsync_out, vsync_oe, px_in_n, px_out_n, slot;
    logic [PW-1:0] pix_cnt;
    logic [VW-1:0] line_cnt;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    vid_sync_gen #(.HW(HW), .VW(VW)) u0 (.*);

    typedef struct packed {
        logic g;
        int hp; int hs; int vp; int vs;
        int e_hper; int e_hlow; int e_vper; int e_vlow;
    } vec_t;

    localparam vec_t VECS [4] = '{
        '{1'b0,  9, 2, 5, 1, 20,  6, 100, 40},
        '{1'b1,  4, 1, 3, 0, 20,  8,  60, 20},
        '{1'b0, 15, 0, 4, 2, 32,  2, 128, 96},
        '{1'b1,  7, 3, 2, 0, 32, 16,  64, 32}
    };

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic measure(input bit vert, output int lowc, output int perc);
        while ((vert ? vsync_out : hsync_out) == 1'b0) @(negedge clk);
        while ((vert ? vsync_out : hsync_out) == 1'b1) @(negedge clk);
        lowc = 0;
        while ((vert ? vsync_out : hsync_out) == 1'b0) begin lowc++; @(negedge clk); end
        perc = lowc;
        while ((vert ? vsync_out : hsync_out) == 1'b1) begin perc++; @(negedge clk); end
    endtask

    // strobe counts over one frame plus position of the first active pixel
    task automatic frame_window(output int n_in, output int n_out, output int fp, output int fl, output int l0);
        bit seen = 1'b0;
        while (vsync_out == 1'b0) @(negedge clk);
        while (vsync_out == 1'b1) @(negedge clk);
        l0 = int'(line_cnt);
        n_in = 0; n_out = 0; fp = -1; fl = -1;
        do begin
            if (!px_in_n) n_in++;
            if (!px_out_n) n_out++;
            if (!seen && (!px_in_n || !px_out_n)) begin
                seen = 1'b1; fp = int'(pix_cnt); fl = int'(line_cnt);
            end
            @(negedge clk);
        end while (!(vsync_out == 1'b0 && line_cnt == 0 && pix_cnt == 0 && slot == 1'b0));
    endtask

    initial begin
        #3_000_000;
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int lo, pe, ni, no, fp, fl, l0, p0, l1;
        bit ok;
        // R11 reset state
        repeat (2) @(negedge clk);
        chk("R11 pix", int'(pix_cnt), 0);
        chk("R11 line", int'(line_cnt), 0);
        chk("R11 hsync low", int'(hsync_out), 0);
        chk("R11 vsync low", int'(vsync_out), 0);
        chk("R11 slot", int'(slot), 0);
        chk("R1 master oe", int'({hsync_oe, vsync_oe}), 3);
        rst = 1'b0;

        // R2 R3 R4 vector table
        foreach (VECS[i]) begin
            gray = VECS[i].g; hperiod = HW'(VECS[i].hp); hsync_w = HW'(VECS[i].hs);
            vperiod = VW'(VECS[i].vp); vsync_w = VW'(VECS[i].vs);
            hdelay = 11'd40; // window off during this part
            do_reset();
            measure(1'b0, lo, pe);
            chk(VECS[i].g ? "R3 hlow" : "R2 hlow", lo, VECS[i].e_hlow);
            chk(VECS[i].g ? "R3 hper" : "R2 hper", pe, VECS[i].e_hper);
            measure(1'b1, lo, pe);
            chk("R4 vlow", lo, VECS[i].e_vlow);
            chk("R4 vper", pe, VECS[i].e_vper);
        end

        // R5 R6 R7 color encode window
        gray = 1'b0; decode = 1'b0; hperiod = 10'd19; hsync_w = 10'd1; hdelay = 11'd3;
        hactive = 10'd1; vperiod = 11'd4; vsync_w = 11'd0; vdelay = 11'd1; vactive = 11'd2;
        do_reset();
        frame_window(ni, no, fp, fl, l0);
        chk("R6 line at vsync fall", l0, 0);
        chk("R7 px_in count", ni, 32);
        chk("R7 px_out idle", no, 0);
        chk("R5 first pixel", fp, 3);
        chk("R6 first line", fl, 1);

        // R8 slot alternation
        while (!(pix_cnt == 5 && slot == 1'b0)) @(negedge clk);
        @(negedge clk);
        chk("R8 write slot", int'({slot, pix_cnt}), (1 << PW) | 5);
        @(negedge clk);
        chk("R8 next pixel", int'({slot, pix_cnt}), 6);

        // R9 stall inside active window
        while (px_in_n) @(negedge clk);
        p0 = int'(pix_cnt); l1 = int'(hsync_out);
        stall = 1'b1;
        ok = 1'b1;
        repeat (10) begin
            @(negedge clk);
            if (!px_in_n || int'(pix_cnt) != p0 || int'(hsync_out) != l1) ok = 1'b0;
        end
        chk("R9 stall freeze", int'(ok), 1);
        stall = 1'b0;
        @(negedge clk); @(negedge clk);
        chk("R9 resumes", int'(pix_cnt), p0 + 1);

        // R3 R5 R7 grayscale decode window
        gray = 1'b1; decode = 1'b1; hperiod = 10'd14; hdelay = 11'd4;
        do_reset();
        frame_window(ni, no, fp, fl, l0);
        chk("R7 px_out count", no, 64);
        chk("R7 px_in idle", ni, 0);
        chk("R5 gray first pixel", fp, 4);

        // R10 R1 slave alignment
        master = 1'b0; hsync_in = 1'b1; vsync_in = 1'b1;
        do_reset();
        chk("R1 slave oe", int'({hsync_oe, vsync_oe}), 0);
        repeat (20) @(negedge clk);
        l0 = int'(line_cnt);
        hsync_in = 1'b0;
        @(negedge clk);
        chk("R10 pix restart", int'(pix_cnt), 0);
        chk("R10 line step", int'(line_cnt), l0 + 1);
        hsync_in = 1'b1;
        repeat (6) @(negedge clk);
        chk("R10 pix after fall", int'(pix_cnt), 3);
        vsync_in = 1'b0;
        @(negedge clk);
        chk("R10 line restart", int'(line_cnt), 0);
        vsync_in = 1'b1;

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule